// File: doc/BRIEF.md
# Debug Unlock Erase Sequencer

This block holds the protection level of a chip's debug port and decides when that level may change. The port can be at one of three levels: full access, restricted access, or permanently disabled. The disabled level exists only when the `HAS_DISABLE` parameter is set. Moving to a weaker level (restricted to full) never happens on request alone. The block must first wipe the main flash array. It then wipes the small security-configuration block and writes that block back. Only after all of this passes does full access open. Moving to a stronger level takes effect on the next clock edge.

The block drives a flash command port that uses a valid/ready handshake. Each command carries an operation, a region and a word address. Once a command is accepted, the sequencer waits for the flash to report completion on `fl_done` before it advances. The `fl_pass` input carries the verify result.

Each region goes through three phases:
- a pre-program pass over every word;
- a single erase pulse;
- a recovery pass that verifies each word and re-programs any over-erased word, up to `RETRY_MAX` times.

The configuration rewrite then programs and verifies each configuration word.

Back-pressure on the command port is absorbed by holding the command steady. While `cmd_valid` is high and `cmd_ready` is low, `cmd_op`, `cmd_region` and `cmd_addr` do not change. At most one command is ever outstanding. The flash may stall `cmd_ready` and `fl_done` for any number of cycles.

Top module: `dbg_unlock_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, level is restricted (2'b01), and busy, done, error and cmd_valid are all 0.
- R2: Level codes are full=2'b00, restricted=2'b01 and disabled=2'b10. A request for restricted while at full takes effect on the next edge and issues no flash command.
- R3: A request for disabled is honoured from full or from restricted when HAS_DISABLE=1. Once disabled, every later request is ignored and no flash command is issued.
- R4: A request for full while at restricted starts the unlock. The commands are issued in this order, with op codes pre-program=0, erase=1, verify=2, program=3 and regions main=0, configuration=1:
  - main pre-program for addresses 0..MAIN_WORDS-1;
  - one main erase at address 0;
  - main recovery;
  - the same three phases for the configuration region;
  - then, for each configuration word, a program followed by a verify.
- R5: In recovery, a verify that reports fl_pass=0 is followed by a program and then a new verify of the same word. A pass moves on to the next word.
- R6: If a word still fails verify after RETRY_MAX programs, the unlock aborts. The block pulses error, stays restricted and issues no further commands.
- R7: A failed verify during the configuration rewrite aborts the unlock with an error pulse, and the level stays restricted.
- R8: busy rises on the edge that accepts the unlock and falls on the edge that raises done or error. Requests made while busy are ignored.
- R9: done is a one-cycle pulse on the cycle the level first reads full. done and error are never high together.
- R10: While cmd_valid is high and cmd_ready is low, the command fields stay stable. cmd_valid is low from the accepting edge until fl_done has been seen.
- R11: A request for the reserved code 2'b11, or for the level already held, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Level-change request strobe |
| req_level | input | 2 | Requested level code |
| cmd_valid | output | 1 | Flash command valid |
| cmd_ready | input | 1 | Flash accepts command |
| cmd_op | output | 2 | Flash operation code |
| cmd_region | output | 1 | 0 main array, 1 configuration block |
| cmd_addr | output | ADDR_W | Word address within region |
| fl_done | input | 1 | Flash finished the accepted command |
| fl_pass | input | 1 | Verify result, valid with fl_done |
| level | output | 2 | Current protection level |
| busy | output | 1 | Unlock in progress |
| done | output | 1 | Unlock completed, one cycle |
| error | output | 1 | Unlock aborted, one cycle |

## Verification
The bench replays flash verify results from a script that it also uses to predict the exact command stream. Clean erases confirm the base phase order. Per-word failure counts below the retry limit exercise the re-program loop. A count of exactly the limit plus one separates "abort after the last retry" from "one retry too few or too many". A scripted failure in the configuration write separates a rewrite abort from a recovery abort. Random ready and completion delays test that the command is held steady under back-pressure. Level requests sent while busy, while disabled, or with the reserved code show that each of them is ignored.

// File: rtl/dbg_unlock_pkg.sv
package dbg_unlock_pkg;
  typedef enum logic [1:0] {
    LVL_FULL     = 2'd0,
    LVL_RESTRICT = 2'd1,
    LVL_DISABLED = 2'd2,
    LVL_RSVD     = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    OP_PREPROG = 2'd0,
    OP_ERASE   = 2'd1,
    OP_VERIFY  = 2'd2,
    OP_PROGRAM = 2'd3
  } fop_e;

  typedef enum logic [1:0] {
    ST_PRE = 2'd0,
    ST_ERS = 2'd1,
    ST_REC = 2'd2,
    ST_WR  = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;
endpackage

// File: rtl/dbg_level_reg.sv
module dbg_level_reg
  import dbg_unlock_pkg::*;
#(
  parameter int HAS_DISABLE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_level,
  input  logic       seq_ok,
  input  logic       seq_err,
  output logic       start,
  output logic [1:0] level,
  output logic       busy,
  output logic       done,
  output logic       error
);
  logic       dis_ok;
  lvl_e       lvl_q, lvl_n;
  logic       busy_q, busy_n;
  logic       done_q, err_q;

  generate
    if (HAS_DISABLE != 0) begin : g_dis
      assign dis_ok = 1'b1;
    end else begin : g_nodis
      assign dis_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    start  = 1'b0;
    lvl_n  = lvl_q;
    busy_n = busy_q;
    if (busy_q) begin
      if (seq_ok) begin
        lvl_n  = LVL_FULL;
        busy_n = 1'b0;
      end else if (seq_err) begin
        busy_n = 1'b0;
      end
    end else if (req_valid) begin
      unique case (lvl_q)
        LVL_RESTRICT: begin
          if (req_level == LVL_FULL) begin
            start  = 1'b1;
            busy_n = 1'b1;
          end else if (req_level == LVL_DISABLED && dis_ok) begin
            lvl_n = LVL_DISABLED;
          end
        end
        LVL_FULL: begin
          if (req_level == LVL_RESTRICT) begin
            lvl_n = LVL_RESTRICT;
          end else if (req_level == LVL_DISABLED && dis_ok) begin
            lvl_n = LVL_DISABLED;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= LVL_RESTRICT;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      lvl_q  <= lvl_n;
      busy_q <= busy_n;
      done_q <= busy_q & seq_ok;
      err_q  <= busy_q & seq_err & ~seq_ok;
    end
  end

  assign level = lvl_q;
  assign busy  = busy_q;
  assign done  = done_q;
  assign error = err_q;
endmodule

// File: rtl/dbg_erase_seq.sv
module dbg_erase_seq
  import dbg_unlock_pkg::*;
#(
  parameter int MAIN_WORDS = 256,
  parameter int CFG_WORDS  = 8,
  parameter int RETRY_MAX  = 16,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic              cmd_region,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              fl_done,
  input  logic              fl_pass,
  output logic              fin_ok,
  output logic              fin_err
);
  localparam int RW = $clog2(RETRY_MAX + 1);
  localparam logic [ADDR_W-1:0] MAIN_LAST = ADDR_W'(MAIN_WORDS - 1);
  localparam logic [ADDR_W-1:0] CFG_LAST  = ADDR_W'(CFG_WORDS - 1);
  localparam logic [RW-1:0]     TRY_LIM   = RW'(RETRY_MAX);

  phase_e            ph_q, ph_n;
  stage_e            st_q, st_n;
  fop_e              op_q, op_n;
  logic              rg_q, rg_n;
  logic [ADDR_W-1:0] ad_q, ad_n;
  logic [RW-1:0]     tr_q, tr_n;
  logic              at_last;

  assign at_last = (ad_q == (rg_q ? CFG_LAST : MAIN_LAST));

  always_comb begin
    ph_n    = ph_q;
    st_n    = st_q;
    op_n    = op_q;
    rg_n    = rg_q;
    ad_n    = ad_q;
    tr_n    = tr_q;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_n = PH_ISSUE;
          st_n = ST_PRE;
          op_n = OP_PREPROG;
          rg_n = 1'b0;
          ad_n = '0;
          tr_n = '0;
        end
      end
      PH_ISSUE: begin
        if (cmd_ready) ph_n = PH_WAIT;
      end
      PH_WAIT: begin
        if (fl_done) begin
          ph_n = PH_ISSUE;
          unique case (st_q)
            ST_PRE: begin
              if (at_last) begin
                st_n = ST_ERS;
                op_n = OP_ERASE;
                ad_n = '0;
              end else begin
                ad_n = ad_q + 1'b1;
              end
            end
            ST_ERS: begin
              st_n = ST_REC;
              op_n = OP_VERIFY;
              ad_n = '0;
              tr_n = '0;
            end
            ST_REC: begin
              if (op_q == OP_PROGRAM) begin
                op_n = OP_VERIFY;
              end else if (fl_pass) begin
                tr_n = '0;
                if (!at_last) begin
                  ad_n = ad_q + 1'b1;
                end else if (!rg_q) begin
                  rg_n = 1'b1;
                  st_n = ST_PRE;
                  op_n = OP_PREPROG;
                  ad_n = '0;
                end else begin
                  st_n = ST_WR;
                  op_n = OP_PROGRAM;
                  ad_n = '0;
                end
              end else if (tr_q == TRY_LIM) begin
                fin_err = 1'b1;
                ph_n    = PH_IDLE;
              end else begin
                op_n = OP_PROGRAM;
                tr_n = tr_q + 1'b1;
              end
            end
            default: begin
              if (op_q == OP_PROGRAM) begin
                op_n = OP_VERIFY;
              end else if (!fl_pass) begin
                fin_err = 1'b1;
                ph_n    = PH_IDLE;
              end else if (at_last) begin
                fin_ok = 1'b1;
                ph_n   = PH_IDLE;
              end else begin
                ad_n = ad_q + 1'b1;
                op_n = OP_PROGRAM;
              end
            end
          endcase
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      st_q <= ST_PRE;
      op_q <= OP_PREPROG;
      rg_q <= 1'b0;
      ad_q <= '0;
      tr_q <= '0;
    end else begin
      ph_q <= ph_n;
      st_q <= st_n;
      op_q <= op_n;
      rg_q <= rg_n;
      ad_q <= ad_n;
      tr_q <= tr_n;
    end
  end

  assign cmd_valid  = (ph_q == PH_ISSUE);
  assign cmd_op     = op_q;
  assign cmd_region = rg_q;
  assign cmd_addr   = ad_q;
endmodule

// File: rtl/dbg_unlock_seq.sv
module dbg_unlock_seq #(
  parameter int MAIN_WORDS  = 256,
  parameter int CFG_WORDS   = 8,
  parameter int RETRY_MAX   = 16,
  parameter int HAS_DISABLE = 1,
  parameter int WORDS_MAX   = (MAIN_WORDS > CFG_WORDS) ? MAIN_WORDS : CFG_WORDS,
  parameter int ADDR_W      = (WORDS_MAX > 1) ? $clog2(WORDS_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_level,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic              cmd_region,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              fl_done,
  input  logic              fl_pass,
  output logic [1:0]        level,
  output logic              busy,
  output logic              done,
  output logic              error
);
  logic start, seq_ok, seq_err;

  dbg_level_reg #(
    .HAS_DISABLE(HAS_DISABLE)
  ) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_level(req_level),
    .seq_ok   (seq_ok),
    .seq_err  (seq_err),
    .start    (start),
    .level    (level),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  dbg_erase_seq #(
    .MAIN_WORDS(MAIN_WORDS),
    .CFG_WORDS (CFG_WORDS),
    .RETRY_MAX (RETRY_MAX),
    .ADDR_W    (ADDR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_region(cmd_region),
    .cmd_addr  (cmd_addr),
    .fl_done   (fl_done),
    .fl_pass   (fl_pass),
    .fin_ok    (seq_ok),
    .fin_err   (seq_err)
  );
endmodule

// File: rtl/dbg_unlock_seq_chk.sv
module dbg_unlock_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              cmd_region,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              fl_done,
  input logic [1:0]        level,
  input logic              busy,
  input logic              done,
  input logic              error
);
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_region) && $stable(cmd_addr)));

  p_cmd_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  p_disabled_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'b10) |=> (level == 2'b10));

  p_full_via_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((level == 2'b00) && ($past(level) == 2'b01)) |-> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_end_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!busy && $past(busy)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  p_err_restricted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (level == 2'b01));
endmodule

bind dbg_unlock_seq dbg_unlock_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_region(cmd_region),
  .cmd_addr  (cmd_addr),
  .fl_done   (fl_done),
  .level     (level),
  .busy      (busy),
  .done      (done),
  .error     (error)
);

// File: tb/dbg_unlock_seq_test.sv
module dbg_unlock_seq_test;
  localparam int MW = 4;
  localparam int CW = 2;
  localparam int RT = 3;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_level = 2'b00;
  logic          cmd_valid, cmd_ready = 1'b0;
  logic [1:0]    cmd_op;
  logic          cmd_region;
  logic [AW-1:0] cmd_addr;
  logic          fl_done = 1'b0, fl_pass = 1'b0;
  logic [1:0]    level;
  logic          busy, done, error;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int exp_op[256], exp_rg[256], exp_ad[256], exp_ps[256];
  int exp_n, exp_err, idx;
  int mfail[MW], cfail[CW], wrfail;

  dbg_unlock_seq #(
    .MAIN_WORDS(MW), .CFG_WORDS(CW), .RETRY_MAX(RT), .HAS_DISABLE(1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_region(cmd_region), .cmd_addr(cmd_addr), .fl_done(fl_done),
    .fl_pass(fl_pass), .level(level), .busy(busy), .done(done), .error(error)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int op, input int rg, input int ad, input int ps);
    exp_op[exp_n] = op; exp_rg[exp_n] = rg; exp_ad[exp_n] = ad; exp_ps[exp_n] = ps;
    exp_n++;
  endtask

  task automatic build_expect();
    exp_n = 0; exp_err = 0;
    for (int r = 0; r < 2 && exp_err == 0; r++) begin
      int w;
      w = (r != 0) ? CW : MW;
      for (int a = 0; a < w; a++) push(0, r, a, 1);
      push(1, r, 0, 1);
      for (int a = 0; a < w && exp_err == 0; a++) begin
        int f;
        f = (r != 0) ? cfail[a] : mfail[a];
        for (int i = 0; i <= RT; i++) begin
          push(2, r, a, (i >= f) ? 1 : 0);
          if (i >= f) break;
          if (i == RT) begin exp_err = 1; break; end
          push(3, r, a, 1);
        end
      end
    end
    if (exp_err == 0) begin
      for (int a = 0; a < CW; a++) begin
        push(3, 1, a, 1);
        push(2, 1, a, (a != wrfail) ? 1 : 0);
        if (a == wrfail) begin exp_err = 1; break; end
      end
    end
  endtask

  // Flash model: replays scripted verify results and checks the command stream (R4, R10)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        int op0, rg0, ad0, p;
        op0 = cmd_op; rg0 = cmd_region; ad0 = cmd_addr;
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(cmd_valid && cmd_op == op0 && cmd_region == rg0 && cmd_addr == ad0,
              "R10 hold", {cmd_op, cmd_region, cmd_addr}, (op0 << 3) | (rg0 << 2) | ad0);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        p = 1;
        if (idx < exp_n) begin
          chk(op0 == exp_op[idx] && rg0 == exp_rg[idx] && ad0 == exp_ad[idx], "R4 order",
              (op0 << 3) | (rg0 << 2) | ad0, (exp_op[idx] << 3) | (exp_rg[idx] << 2) | exp_ad[idx]);
          p = exp_ps[idx];
        end else begin
          chk(1'b0, "R4 extra command", idx, exp_n);
        end
        idx++;
        chk(!cmd_valid, "R10 valid drop", cmd_valid, 0);
        repeat ($urandom % 3) @(negedge clk);
        fl_done = 1'b1; fl_pass = p[0];
        @(negedge clk);
        fl_done = 1'b0; fl_pass = 1'b0;
      end
    end
  end

  task automatic send_req(input logic [1:0] lv);
    @(negedge clk);
    req_valid = 1'b1; req_level = lv;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_unlock(input bit poke);
    int t;
    build_expect();
    idx = 0;
    send_req(2'b00);
    chk(busy == 1'b1, "R8 busy on accept", busy, 1);
    if (poke) begin
      req_valid = 1'b1; req_level = 2'b10;
      @(negedge clk);
      req_valid = 1'b0;
      chk(level == 2'b01 && busy, "R8 ignore while busy", level, 1);
    end
    t = 0;
    while (!(done || error) && t < 5000) begin @(negedge clk); t++; end
    chk(done == (exp_err == 0), "R6 R7 outcome done", done, exp_err == 0);
    chk(error == (exp_err != 0), "R6 R7 outcome error", error, exp_err != 0);
    chk(level == ((exp_err != 0) ? 2'b01 : 2'b00), "R9 level at end", level, (exp_err != 0) ? 1 : 0);
    chk(idx == exp_n, "R5 command count", idx, exp_n);
    chk(!busy, "R8 busy end", busy, 0);
    @(negedge clk);
    chk(!done && !error, "R9 pulse width", {done, error}, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!cmd_valid, "R6 quiet after end", cmd_valid, 0);
    end
    if (level == 2'b00) begin
      send_req(2'b01);
      chk(level == 2'b01, "R2 full to restricted", level, 1);
    end
  endtask

  task automatic clear_fails();
    for (int i = 0; i < MW; i++) mfail[i] = 0;
    for (int i = 0; i < CW; i++) cfail[i] = 0;
    wrfail = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    exp_n = 0; idx = 0;
    clear_fails();
    repeat (3) @(negedge clk);
    chk(level == 2'b01 && !busy && !done && !error && !cmd_valid, "R1 in reset", level, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level == 2'b01 && !busy && !done && !error && !cmd_valid, "R1 after reset", level, 1);

    send_req(2'b11);
    chk(level == 2'b01 && !busy, "R11 reserved code", level, 1);
    send_req(2'b01);
    chk(level == 2'b01 && !busy && !cmd_valid, "R11 same level", level, 1);

    do_unlock(1'b0);                       // R4 clean
    mfail[1] = 2; cfail[0] = 1;
    do_unlock(1'b1);                       // R5 retries
    clear_fails(); mfail[2] = RT + 1;
    do_unlock(1'b0);                       // R6 limit exceeded
    clear_fails(); mfail[0] = RT;
    do_unlock(1'b0);                       // R6 exactly at limit passes
    clear_fails(); wrfail = 1;
    do_unlock(1'b0);                       // R7 rewrite fails

    for (int k = 0; k < 10; k++) begin
      clear_fails();
      for (int i = 0; i < MW; i++) mfail[i] = $urandom % (RT + 1);
      for (int i = 0; i < CW; i++) cfail[i] = $urandom % (RT + 1);
      if ($urandom % 6 == 0) mfail[$urandom % MW] = RT + 1;
      if ($urandom % 5 == 0) wrfail = $urandom % CW;
      do_unlock(k[0]);
    end

    clear_fails();
    do_unlock(1'b0);
    send_req(2'b00);                       // back at restricted: unlock to full
    begin
      int t = 0;
      build_expect(); idx = 0;
      while (!done && t < 5000) begin @(negedge clk); t++; end
      @(negedge clk);
    end
    chk(level == 2'b00, "R9 full reached", level, 0);
    send_req(2'b10);
    chk(level == 2'b10, "R3 full to disabled", level, 2);
    send_req(2'b00);
    chk(level == 2'b10 && !busy, "R3 leave to full ignored", level, 2);
    send_req(2'b01);
    chk(level == 2'b10 && !busy && !cmd_valid, "R3 leave to restricted ignored", level, 2);

    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(level == 2'b01, "R1 re-reset", level, 1);
    send_req(2'b10);
    chk(level == 2'b10 && !busy, "R3 restricted to disabled", level, 2);
    repeat (4) begin
      @(negedge clk);
      chk(!cmd_valid && level == 2'b10, "R3 no commands", cmd_valid, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule